// File: doc/BRIEF.md
# DDR Read Data Serializer

This block is the read output path of a double-data-rate memory device. Each clock, the column array returns one word that is twice the width of the data bus. The block splits that word into two beats: one is driven while the clock is high and the other while it is low. Alongside the data it drives a strobe whose edges coincide with the data changes. It also drives a single output enable that tells the pads when to drive data and strobe and when to float.

When a registered read command arrives, an internal burst generator issues one aligned column-pair read per clock to the array. The array is a synchronous port that returns its word one clock after the address. The returned words pass through a short delay line so that the first beat appears exactly the programmed CAS latency after the command. Bit 0 of the starting column decides which half of each pair leaves first. The strobe is driven low for a full clock before the first beat as a preamble. After the last beat it stays low for half a clock as a postamble, and then it is released.

CAS latency and burst length are configuration inputs. They are held stable while reads are in flight. A read that arrives during a burst cuts that burst short, and the new data follows it with no gap.

Top module: `ddr_rd_serializer`

## Requirements
- R1: While reset is asserted and after its release with no command, `readOe` is 0, `dqs` is 0, `dq` is all zeros and `coreRdEn` is 0.
- R2: For a read command sampled at rising edge T, `coreRdEn` is high in the following cycle, and the first beat is driven in the clock-high half of cycle T+L. Here L is `casLat`: 2 or 3, with values below 2 treated as 2 and values above 3 treated as 3. Cycles T to T+L-2 other than the preamble show `readOe` low.
- R3: Each array word holds column 2p in bits 31:0 and column 2p+1 in bits 63:32. When bit 0 of the start column is 0, bits 31:0 go out in the high half and bits 63:32 in the low half. When it is 1, the order is reversed.
- R4: `burstLen` code 0, 1, 2 or 3 gives bursts of 2, 4, 8 or 256 beats, that is 1, 2, 4 or 128 clocks. Pair k of a burst is the start pair with its low pair-index bits advanced by k, wrapping within the aligned block of the burst's size. The upper bits stay fixed.
- R5: During every beat clock, `dqs` is 1 in the high half and 0 in the low half, and `readOe` is 1 in both halves.
- R6: In the clock before the first beat, `readOe` is 1 and `dqs` is 0 in both halves, and `dq` is zero.
- R7: In the clock after the last beat, `readOe` is 1 and `dqs` is 0 in the high half, and `readOe` is 0 in the low half.
- R8: Outside preamble, beat and postamble halves, `readOe` is 0. `dq` is zero whenever no beat is driven.
- R9: A read command sampled while a burst is being fetched ends that fetch. The array address restarts at the new column's pair. The new burst's beats follow the truncated burst's last beat in the very next clock, with no preamble in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also selects the beat shown on the DDR outputs |
| rstN | input | 1 | Asynchronous active-low reset |
| readCmd | input | 1 | Registered read command, one cycle wide |
| readCol | input | 8 | Starting column of the read |
| casLat | input | 2 | CAS latency in clocks (2 or 3) |
| burstLen | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=256 beats |
| coreRdEn | output | 1 | Array read strobe, one pair per clock |
| coreAddr | output | 7 | Array column-pair address |
| coreData | input | 64 | Array word, valid the clock after the address |
| dq | output | 32 | DDR data, high-half beat then low-half beat |
| dqs | output | 1 | Edge-aligned read strobe |
| readOe | output | 1 | Output enable for `dq` and `dqs` |

## Verification
A wrong swap bit or a misaligned delay-line tap shows up at once: the first beat clock carries the wrong half or the wrong pair, in its very first half-cycle. A burst counter that loses count shows within one clock of the expected end, either as an early postamble or as a missing one. A stale valid bit after truncation shows up as an unwanted preamble between the two bursts, or as a beat of the old burst at the restart point. The bench therefore checks both halves of every clock from command to idle, against words whose values encode their own column number.

// File: rtl/rdser_pkg.sv
package rdser_pkg;

  // Strobes passed from control to datapath each clock.
  typedef struct packed {
    logic beat;  // a data pair is output next cycle
    logic swap;  // upper half goes out first
    logic pre;   // next cycle is the strobe preamble
    logic post;  // next cycle is the strobe postamble
  } rdStrobeT;

  function automatic int clampLat(input int req, input int maxLat);
    if (req < 2) return 2;
    if (req > maxLat) return maxLat;
    return req;
  endfunction

endpackage

// File: rtl/rdser_ctrl.sv
module rdser_ctrl
  import rdser_pkg::*;
#(
  parameter int COL_W   = 8,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int PAIR_W = COL_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              readCmd,
  input  logic [COL_W-1:0]  readCol,
  input  logic [LAT_W-1:0]  casLat,
  input  logic [1:0]        burstLen,
  output logic              coreRdEn,
  output logic [PAIR_W-1:0] coreAddr,
  output rdStrobeT          strb
);

  logic              active;
  logic              swapQ;
  logic              wasBeat;
  logic [PAIR_W-1:0] basePair;
  logic [PAIR_W-1:0] offset;
  logic [PAIR_W-1:0] maskQ;
  logic [PAIR_W:0]   remain;
  logic [PAIR_W:0]   pairsNew;

  // Burst length code to number of clocks (pairs)
  always_comb begin
    case (burstLen)
      2'd0:    pairsNew = (PAIR_W+1)'(1);
      2'd1:    pairsNew = (PAIR_W+1)'(2);
      2'd2:    pairsNew = (PAIR_W+1)'(4);
      default: pairsNew = (PAIR_W+1)'(1) << PAIR_W;
    endcase
  end

  // Burst generator: a new command always restarts it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      swapQ    <= 1'b0;
      basePair <= '0;
      offset   <= '0;
      maskQ    <= '0;
      remain   <= '0;
    end else if (readCmd) begin
      active   <= 1'b1;
      swapQ    <= readCol[0];
      basePair <= readCol[COL_W-1:1];
      offset   <= '0;
      maskQ    <= PAIR_W'(pairsNew - 1'b1);
      remain   <= pairsNew;
    end else if (active) begin
      offset <= offset + 1'b1;
      remain <= remain - 1'b1;
      if (remain == (PAIR_W+1)'(1)) active <= 1'b0;
    end
  end

  assign coreRdEn = active;
  assign coreAddr = (basePair & ~maskQ) | ((basePair + offset) & maskQ);

  // Valid and swap travel beside the array word; index 0 is the fetch cycle
  logic [MAX_LAT-1:0] vAll;
  logic [MAX_LAT-1:0] sAll;
  logic [MAX_LAT-1:1] vDly;
  logic [MAX_LAT-1:1] sDly;

  assign vAll = {vDly, active};
  assign sAll = {sDly, swapQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vDly <= '0;
      sDly <= '0;
    end else begin
      vDly <= vAll[MAX_LAT-2:0];
      sDly <= sAll[MAX_LAT-2:0];
    end
  end

  int  lat;
  logic tapValid;
  logic lookValid;

  always_comb begin
    lat       = clampLat(int'(casLat), MAX_LAT);
    tapValid  = vAll[lat-1];
    lookValid = vAll[lat-2];
    strb.beat = tapValid;
    strb.swap = sAll[lat-1];
    strb.pre  = !tapValid && lookValid;
    strb.post = !tapValid && !lookValid && wasBeat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wasBeat <= 1'b0;
    else       wasBeat <= tapValid;
  end

endmodule

// File: rtl/rdser_datapath.sv
module rdser_datapath
  import rdser_pkg::*;
#(
  parameter int DQ_W    = 32,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1),
  localparam int WORD_W = 2 * DQ_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] coreData,
  input  logic [LAT_W-1:0]  casLat,
  input  rdStrobeT          strb,
  output logic [DQ_W-1:0]   dq,
  output logic              dqs,
  output logic              readOe
);

  // Latency delay line; index 0 is the array output
  logic [MAX_LAT-2:0][WORD_W-1:0] dAll;
  logic [MAX_LAT-2:1][WORD_W-1:0] dDly;

  assign dAll = {dDly, coreData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dDly <= '0;
    else       dDly <= dAll[MAX_LAT-3:0];
  end

  int lat;
  logic [WORD_W-1:0] tapWord;

  always_comb begin
    lat     = clampLat(int'(casLat), MAX_LAT);
    tapWord = dAll[lat-2];
  end

  // Output registers for both clock halves
  logic [DQ_W-1:0] riseQ;
  logic [DQ_W-1:0] fallQ;
  logic            oeHiQ;
  logic            oeLoQ;
  logic            dqsHiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ  <= '0;
      fallQ  <= '0;
      oeHiQ  <= 1'b0;
      oeLoQ  <= 1'b0;
      dqsHiQ <= 1'b0;
    end else begin
      if (strb.beat) begin
        riseQ <= strb.swap ? tapWord[WORD_W-1:DQ_W] : tapWord[DQ_W-1:0];
        fallQ <= strb.swap ? tapWord[DQ_W-1:0] : tapWord[WORD_W-1:DQ_W];
      end else begin
        riseQ <= '0;
        fallQ <= '0;
      end
      oeHiQ  <= strb.beat | strb.pre | strb.post;
      oeLoQ  <= strb.beat | strb.pre;
      dqsHiQ <= strb.beat;
    end
  end

  // Clock-phase selection gives the double-rate output
  assign dq     = clk ? riseQ : fallQ;
  assign dqs    = clk ? dqsHiQ : 1'b0;
  assign readOe = clk ? oeHiQ : oeLoQ;

endmodule

// File: rtl/ddr_rd_serializer.sv
module ddr_rd_serializer
  import rdser_pkg::*;
#(
  parameter int DQ_W    = 32,
  parameter int COL_W   = 8,
  parameter int MAX_LAT = 3,
  localparam int LAT_W  = $clog2(MAX_LAT + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                readCmd,
  input  logic [COL_W-1:0]    readCol,
  input  logic [LAT_W-1:0]    casLat,
  input  logic [1:0]          burstLen,
  output logic                coreRdEn,
  output logic [COL_W-2:0]    coreAddr,
  input  logic [2*DQ_W-1:0]   coreData,
  output logic [DQ_W-1:0]     dq,
  output logic                dqs,
  output logic                readOe
);

  rdStrobeT strb;

  rdser_ctrl #(
    .COL_W   (COL_W),
    .MAX_LAT (MAX_LAT)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .readCmd  (readCmd),
    .readCol  (readCol),
    .casLat   (casLat),
    .burstLen (burstLen),
    .coreRdEn (coreRdEn),
    .coreAddr (coreAddr),
    .strb     (strb)
  );

  rdser_datapath #(
    .DQ_W    (DQ_W),
    .MAX_LAT (MAX_LAT)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .coreData (coreData),
    .casLat   (casLat),
    .strb     (strb),
    .dq       (dq),
    .dqs      (dqs),
    .readOe   (readOe)
  );

endmodule

// File: rtl/rdser_chk.sv
module rdser_chk
  import rdser_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             readCmd,
  input logic [COL_W-1:0] readCol,
  input logic [1:0]       burstLen,
  input logic             coreRdEn,
  input logic [COL_W-2:0] coreAddr,
  input rdStrobeT         strb
);

  // A command starts array fetches in the next cycle
  assert_fetch_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    readCmd |=> coreRdEn);

  // Shortest burst occupies exactly one fetch clock
  assert_short_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdEn && !readCmd && burstLen == 2'd0 && $stable(burstLen)) |=> !coreRdEn);

  // Beat, preamble and postamble never overlap
  assert_phase_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.beat, strb.pre, strb.post}));

  // A preamble clock is always followed by a beat clock
  assert_pre_then_beat_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pre |=> strb.beat);

  // A postamble follows only directly after a beat
  assert_post_after_beat_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.post |-> $past(strb.beat));

  // A command during a burst restarts fetching at the new pair
  assert_restart_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    (readCmd && coreRdEn) |=> (coreRdEn && coreAddr == $past(readCol[COL_W-1:1])));

endmodule

bind ddr_rd_serializer rdser_chk #(.COL_W(COL_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .readCmd  (readCmd),
  .readCol  (readCol),
  .burstLen (burstLen),
  .coreRdEn (coreRdEn),
  .coreAddr (coreAddr),
  .strb     (strb)
);

// File: tb/test_ddr_rd_serializer.sv
module test_ddr_rd_serializer;

  logic        clk;
  logic        rstN;
  logic        readCmd;
  logic [7:0]  readCol;
  logic [1:0]  casLat;
  logic [1:0]  burstLen;
  logic        coreRdEn;
  logic [6:0]  coreAddr;
  logic [63:0] coreData;
  logic [31:0] dq;
  logic        dqs;
  logic        readOe;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  ddr_rd_serializer i_ddr_rd_serializer (
    .clk      (clk),
    .rstN     (rstN),
    .readCmd  (readCmd),
    .readCol  (readCol),
    .casLat   (casLat),
    .burstLen (burstLen),
    .coreRdEn (coreRdEn),
    .coreAddr (coreAddr),
    .coreData (coreData),
    .dq       (dq),
    .dqs      (dqs),
    .readOe   (readOe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] wordOf(input int c);
    return 32'hD0A5_0000 | 32'(c);
  endfunction

  // Array model: one-clock synchronous read of a column pair
  always_ff @(posedge clk) begin
    if (coreRdEn) coreData <= {wordOf(2 * int'(coreAddr) + 1), wordOf(2 * int'(coreAddr))};
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic phaseHi();
    @(posedge clk); #2;
  endtask

  task automatic phaseLo();
    @(negedge clk); #2;
  endtask

  function automatic int pairsOf(input logic [1:0] code);
    case (code)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 128;
    endcase
  endfunction

  function automatic int pairAt(input logic [7:0] col, input logic [1:0] code, input int k);
    int base = int'(col[7:1]);
    int m    = pairsOf(code) - 1;
    return (base & ~m & 127) | ((base + k) & m);
  endfunction

  task automatic expIdle(input string req);
    phaseHi();
    chk(req, "oe high half idle", 32'(readOe), 32'd0);
    chk(req, "dq idle", dq, 32'd0);
    phaseLo();
    chk(req, "oe low half idle", 32'(readOe), 32'd0);
  endtask

  task automatic expPre();
    phaseHi();
    chk("R6", "preamble oe high half", 32'(readOe), 32'd1);
    chk("R6", "preamble dqs high half", 32'(dqs), 32'd0);
    chk("R8", "preamble dq zero", dq, 32'd0);
    phaseLo();
    chk("R6", "preamble oe low half", 32'(readOe), 32'd1);
    chk("R6", "preamble dqs low half", 32'(dqs), 32'd0);
  endtask

  task automatic expBeat(input string req, input logic [31:0] first, input logic [31:0] second);
    phaseHi();
    chk(req, "first beat data", dq, first);
    chk("R5", "strobe high with first beat", 32'(dqs), 32'd1);
    chk("R5", "oe with first beat", 32'(readOe), 32'd1);
    phaseLo();
    chk(req, "second beat data", dq, second);
    chk("R5", "strobe low with second beat", 32'(dqs), 32'd0);
    chk("R5", "oe with second beat", 32'(readOe), 32'd1);
  endtask

  task automatic expBurst(input string req, input logic [7:0] col, input logic [1:0] code,
                          input int nPairs);
    for (int k = 0; k < nPairs; k++) begin
      int p = pairAt(col, code, k);
      if (col[0]) expBeat(req, wordOf(2 * p + 1), wordOf(2 * p));
      else        expBeat(req, wordOf(2 * p), wordOf(2 * p + 1));
    end
  endtask

  task automatic expPost();
    phaseHi();
    chk("R7", "postamble oe high half", 32'(readOe), 32'd1);
    chk("R7", "postamble dqs low", 32'(dqs), 32'd0);
    chk("R8", "postamble dq zero", dq, 32'd0);
    phaseLo();
    chk("R7", "postamble oe released", 32'(readOe), 32'd0);
  endtask

  task automatic issue(input logic [7:0] col);
    @(negedge clk);
    readCmd = 1'b1;
    readCol = col;
    @(negedge clk);
    readCmd = 1'b0;
  endtask

  // Single read checked from command to idle (R2, R3, R4)
  task automatic runRead(input string req, input logic [7:0] col,
                         input logic [1:0] code, input int lat);
    burstLen = code;
    casLat   = 2'(lat);
    repeat (2) @(negedge clk);
    issue(col);
    for (int i = 0; i < lat - 2; i++) expIdle("R2");
    expPre();
    expBurst(req, col, code, pairsOf(code));
    expPost();
    expIdle("R8");
  endtask

  task automatic testReset();
    phaseHi();
    chk("R1", "oe in reset", 32'(readOe), 32'd0);
    chk("R1", "dqs in reset", 32'(dqs), 32'd0);
    chk("R1", "dq in reset", dq, 32'd0);
    chk("R1", "coreRdEn in reset", 32'(coreRdEn), 32'd0);
    @(negedge clk);
    rstN = 1'b1;
    phaseHi();
    chk("R1", "oe after reset", 32'(readOe), 32'd0);
    chk("R1", "coreRdEn after reset", 32'(coreRdEn), 32'd0);
    phaseLo();
    chk("R1", "dq after reset", dq, 32'd0);
  endtask

  // R9: second read two clocks into an 8-beat burst, latency 2
  task automatic testTruncate();
    burstLen = 2'd2;
    casLat   = 2'd2;
    repeat (2) @(negedge clk);
    @(negedge clk);
    readCmd = 1'b1;
    readCol = 8'h40;
    fork
      begin
        @(negedge clk); readCmd = 1'b0;
        @(negedge clk); readCmd = 1'b1; readCol = 8'h81;
        @(negedge clk); readCmd = 1'b0;
      end
      begin
        expIdle("R9");
        expPre();
        expBurst("R9", 8'h40, 2'd2, 2);
        expBurst("R9", 8'h81, 2'd2, 4);
        expPost();
        expIdle("R9");
      end
    join
  endtask

  initial begin
    rstN     = 1'b0;
    readCmd  = 1'b0;
    readCol  = '0;
    casLat   = 2'd2;
    burstLen = 2'd0;
    coreData = '0;
    repeat (2) @(negedge clk);
    testReset();
    runRead("R3", 8'h10, 2'd1, 2);
    runRead("R4", 8'h25, 2'd2, 3);
    runRead("R3", 8'h07, 2'd0, 2);
    runRead("R4", 8'hFE, 2'd3, 3);
    runRead("R2", 8'h00, 2'd1, 1);
    testTruncate();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule